// File: doc/BRIEF.md
# Serial Byte Transmitter with Clear-to-Send Gating

This block turns bytes into asynchronous serial frames on a single output line. Bytes enter through a valid/ready port into a small queue. Each frame is built from the oldest queued byte and the configuration inputs present at that moment. The configuration chooses a 7- or 8-bit word, parity off, odd or even, and one or two stop bits.

Bit timing comes from an external one-cycle baud tick. Every frame bit lasts exactly one tick period. Frames may follow each other with no idle gap.

When flow control is enabled, an active-low clear-to-send input is synchronised and then consulted only when a new frame could begin. Raising it in the middle of a frame does not cut that frame short. It only stops the next frame from starting.

Top module: `sertx_core`

## Requirements
- R1: After reset `tx_out` is 1, `busy` is 0 and `in_ready` is 1; while no frame is in progress `tx_out` stays 1.
- R2: A frame is, in time order: one start bit at 0, the data bits least significant first, the parity bit when `cfg_par_en`=1, then the stop bits at 1. `busy` is 1 from the start bit through the last stop bit.
- R3: With `cfg_len8`=0 only `in_data[6:0]` is sent (7 data bits) and `in_data[7]` has no effect on the line. With `cfg_len8`=1 all 8 bits are sent.
- R4: With `cfg_par_odd`=0 (even) the parity bit is the XOR of the sent data bits. With `cfg_par_odd`=1 (odd) it is the inverse of that XOR.
- R5: `cfg_stop2`=0 gives one stop bit and `cfg_stop2`=1 gives two.
- R6: With `cfg_flow_en`=1 a frame starts only while the synchronised `cts_n` is 0. While `cts_n` stays 1 the line stays high even when bytes are queued.
- R7: With `cfg_flow_en`=1, a rise of `cts_n` during a frame lets that frame finish unchanged, and no further frame starts until `cts_n` returns to 0.
- R8: With `cfg_flow_en`=0, `cts_n` is ignored and a frame starts on the first baud tick at which a byte is queued.
- R9: Configuration inputs are captured when a frame starts. Changing them during a frame affects only later frames.
- R10: `tx_out` changes only on clock edges where `baud_tick`=1, so each bit lasts one tick period. A queued byte starts its frame on the very tick that ends the previous frame's last stop bit.
- R11: The queue holds `DEPTH` bytes (default 4) and sends them in arrival order. `in_ready` is 0 while `DEPTH` bytes are waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Byte to queue |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Queue can accept a byte |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: append a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_flow_en | input | 1 | 1: gate frame starts with `cts_n` |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| tx_out | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is on the line |

## Verification
Known bytes are sent in several formats:
- 8 data bits with no parity and one stop bit;
- 7 data bits with even parity, using one byte whose eighth bit is set and one whose only set bit is the eighth;
- odd parity with two stop bits, sent back to back.

These patterns separate bit order, word-length masking, parity polarity and stop-bit count. The back-to-back case also shows any gap or overlap between frames.

Flow control is tried in four ways:
- the line held off with a byte queued;
- released;
- withdrawn in the middle of a frame, which must finish that frame and then hold the line high;
- ignored when flow control is off.

A configuration change during a frame shows that settings are captured per frame. Filling the queue while held off checks the full indication and the arrival order of the bytes.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W    = 8;
    localparam int FRAME_MAX = 1 + DATA_W + 1 + 2;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        logic len8;
        logic par_en;
        logic par_odd;
        logic stop2;
    } txcfg_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;   // bit 0 goes out first
        logic [CNT_W-1:0]     nbits;
    } frame_t;

    function automatic logic [DATA_W-1:0] mask_word(logic [DATA_W-1:0] d, txcfg_t c);
        return c.len8 ? d : {1'b0, d[DATA_W-2:0]};
    endfunction

    function automatic logic par_bit(logic [DATA_W-1:0] d, txcfg_t c);
        logic x;
        x = ^mask_word(d, c);
        return c.par_odd ? ~x : x;
    endfunction

    function automatic frame_t build_frame(logic [DATA_W-1:0] d, txcfg_t c);
        frame_t f;
        int     p;
        f.bits    = '1;
        f.bits[0] = 1'b0;
        p = 1;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < DATA_W - 1 || c.len8) begin
                f.bits[p] = d[i];
                p++;
            end
        end
        if (c.par_en) begin
            f.bits[p] = par_bit(d, c);
            p++;
        end
        p = p + (c.stop2 ? 2 : 1);
        f.nbits = CNT_W'(p);
        return f;
    endfunction

endpackage

// File: rtl/sertx_sync.sv
module sertx_sync #(
    parameter int STAGES = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_one
            logic r;
            always_ff @(posedge clk) begin
                if (rst) r <= RST_VAL;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] r;
            always_ff @(posedge clk) begin
                if (rst) r <= {STAGES{RST_VAL}};
                else     r <= {r[STAGES-2:0], d};
            end
            assign q = r[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty,
    output logic [CW-1:0] fill
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          wr_ok, rd_ok;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign wr_ok = wr && !full;
    assign rd_ok = rd && !empty;
    assign rdata = mem[rp];
    assign fill  = cnt;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_ok) wp <= bump(wp);
            if (rd_ok) rp <= bump(rp);
            case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              go,
    input  logic [DATA_W-1:0] head,
    input  txcfg_t            cfg,
    output logic              take,
    output logic              tx_out,
    output logic              busy
);
    logic [FRAME_MAX-1:0] sh;
    logic [CNT_W-1:0]     left;
    logic                 at_end;
    frame_t               nxt;

    assign at_end = (left <= CNT_W'(1));
    assign take   = tick && at_end && go;
    assign nxt    = build_frame(head, cfg);
    assign tx_out = sh[0];
    assign busy   = (left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            left <= '0;
        end else if (tick) begin
            if (!at_end) begin
                sh   <= {1'b1, sh[FRAME_MAX-1:1]};
                left <= left - 1'b1;
            end else if (go) begin
                sh   <= nxt.bits;
                left <= nxt.nbits;
            end else begin
                sh   <= '1;
                left <= '0;
            end
        end
    end
endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int FILL_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              cfg_len8,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_stop2,
    input  logic              cfg_flow_en,
    input  logic              baud_tick,
    input  logic              cts_n,
    output logic              tx_out,
    output logic              busy
);
    logic              cts_act_n;
    logic              q_full, q_empty, take, go;
    logic [DATA_W-1:0] head;
    logic [FILL_W-1:0] fill;
    txcfg_t            cfg;

    assign cfg = '{len8: cfg_len8, par_en: cfg_par_en,
                   par_odd: cfg_par_odd, stop2: cfg_stop2};

    sertx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts (
        .clk(clk), .rst(rst), .d(cts_n), .q(cts_act_n)
    );

    sertx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_q (
        .clk(clk), .rst(rst),
        .wr(in_valid), .wdata(in_data),
        .rd(take), .rdata(head),
        .full(q_full), .empty(q_empty), .fill(fill)
    );

    assign in_ready = !q_full;
    assign go       = !q_empty && (!cfg_flow_en || !cts_act_n);

    sertx_framer u_fr (
        .clk(clk), .rst(rst), .tick(baud_tick), .go(go),
        .head(head), .cfg(cfg),
        .take(take), .tx_out(tx_out), .busy(busy)
    );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int DEPTH  = 4,
    parameter int FILL_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              baud_tick,
    input logic              tx_out,
    input logic              busy,
    input logic              cfg_flow_en,
    input logic              cts_q,
    input logic              in_ready,
    input logic [FILL_W-1:0] fill
);
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_out);

    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx_out);

    a_r10_change_on_tick: assert property (@(posedge clk) disable iff (rst)
        !baud_tick |=> $stable(tx_out));

    a_r6_cts_gate: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && $past(cfg_flow_en)) |-> !$past(cts_q));

    a_r11_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (fill == FILL_W'(DEPTH)) |-> !in_ready);
endmodule

bind sertx_core sertx_chk #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_out(tx_out),
    .busy(busy), .cfg_flow_en(cfg_flow_en), .cts_q(cts_act_n),
    .in_ready(in_ready), .fill(fill)
);

// File: tb/sertx_core_tb.sv
module sertx_core_tb_top;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0, cfg_flow_en = 1'b0;
    logic       baud_tick = 1'b0;
    logic       cts_n = 1'b1;
    logic       tx_out, busy;

    int checks = 0;
    int errors = 0;
    int tcnt = 0;

    always #2.5 clk = ~clk;

    sertx_core dut_i (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
        .cfg_flow_en(cfg_flow_en), .baud_tick(baud_tick), .cts_n(cts_n),
        .tx_out(tx_out), .busy(busy)
    );

    always @(negedge clk) begin
        if (rst) begin
            tcnt = 0;
            baud_tick = 1'b0;
        end else begin
            tcnt = (tcnt == DIV - 1) ? 0 : tcnt + 1;
            baud_tick = (tcnt == DIV - 1);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic void exp_frame(input logic [7:0] d, output logic [15:0] fr,
                                      output int n);
        logic [7:0] w;
        int nd, k, ones;
        logic pb;
        nd   = cfg_len8 ? 8 : 7;
        w    = cfg_len8 ? d : (d & 8'h7F);
        ones = $countones(w);
        pb   = cfg_par_odd ? (ones % 2 == 0) : (ones % 2 == 1);
        fr   = '1;
        fr[0] = 1'b0;
        for (int i = 0; i < nd; i++) fr[1 + i] = w[i];
        k = 1 + nd;
        if (cfg_par_en) begin
            fr[k] = pb;
            k++;
        end
        n = k + (cfg_stop2 ? 2 : 1);
    endfunction

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Receives one frame; cont=1 means it follows directly on the previous one.
    task automatic rx(input logic [7:0] b, input bit cont, input string req);
        logic [15:0] fr, got;
        int n, waited;
        exp_frame(b, fr, n);
        got = '1;
        if (cont) begin
            repeat (DIV) @(negedge clk);
        end else begin
            waited = 0;
            @(negedge clk);
            while (tx_out && waited < 40 * DIV) begin
                @(negedge clk);
                waited++;
            end
            repeat (DIV / 2) @(negedge clk);
        end
        for (int i = 0; i < n; i++) begin
            if (i > 0) repeat (DIV) @(negedge clk);
            got[i] = tx_out;
        end
        check(got == fr, req, "frame bits", got, fr);
    endtask

    task automatic quiet(input int cycles, input string req);
        int lows = 0, busies = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (!tx_out) lows++;
            if (busy) busies++;
        end
        check(lows == 0 && busies == 0, req, "line held idle",
              16'(lows + busies), 16'h0);
    endtask

    task automatic set_cfg(input bit l8, input bit pe, input bit po, input bit s2,
                           input bit fl);
        @(negedge clk);
        cfg_len8 = l8; cfg_par_en = pe; cfg_par_odd = po;
        cfg_stop2 = s2; cfg_flow_en = fl;
    endtask

    task automatic t_reset;
        check(tx_out == 1'b1, "R1", "tx after reset", 16'(tx_out), 16'h1);
        check(busy == 1'b0, "R1", "busy after reset", 16'(busy), 16'h0);
        check(in_ready == 1'b1, "R1", "ready after reset", 16'(in_ready), 16'h1);
    endtask

    task automatic t_8n1;
        set_cfg(1, 0, 0, 0, 0);
        push(8'hA5);
        rx(8'hA5, 0, "R2");
        repeat (DIV) @(negedge clk);
        check(busy == 1'b0 && tx_out == 1'b1, "R2", "idle after frame",
              16'({busy, tx_out}), 16'h1);
    endtask

    task automatic t_7bit_even;
        set_cfg(0, 1, 0, 0, 0);
        push(8'hFF);
        rx(8'hFF, 0, "R3 R4 even parity, 7 ones");
        repeat (2 * DIV) @(negedge clk);
        push(8'h80);
        rx(8'h80, 0, "R3 eighth bit ignored");
        repeat (2 * DIV) @(negedge clk);
    endtask

    task automatic t_odd_2stop;
        set_cfg(1, 1, 1, 1, 0);
        push(8'h3C);
        push(8'h01);
        rx(8'h3C, 0, "R4 R5 odd parity two stops");
        rx(8'h01, 1, "R10 back to back");
        repeat (2 * DIV) @(negedge clk);
    endtask

    task automatic t_cfg_hold;
        set_cfg(1, 0, 0, 0, 0);
        push(8'h55);
        push(8'h0F);
        fork
            rx(8'h55, 0, "R9 first frame unaffected");
            begin
                repeat (3 * DIV) @(negedge clk);
                cfg_par_en = 1'b1;
                cfg_stop2 = 1'b1;
            end
        join
        rx(8'h0F, 1, "R9 next frame uses new config");
        repeat (2 * DIV) @(negedge clk);
    endtask

    task automatic t_flow_block;
        set_cfg(1, 0, 0, 0, 1);
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        push(8'h99);
        quiet(10 * DIV, "R6 held off");
        cts_n = 1'b0;
        rx(8'h99, 0, "R6 released");
        repeat (2 * DIV) @(negedge clk);
    endtask

    task automatic t_cts_mid;
        set_cfg(1, 0, 0, 0, 1);
        cts_n = 1'b0;
        repeat (4) @(negedge clk);
        push(8'h12);
        push(8'h34);
        fork
            rx(8'h12, 0, "R7 frame completes");
            begin
                @(negedge clk);
                while (tx_out) @(negedge clk);
                repeat (2 * DIV) @(negedge clk);
                cts_n = 1'b1;
            end
        join
        repeat (DIV) @(negedge clk);
        quiet(8 * DIV, "R7 no new frame");
        cts_n = 1'b0;
        rx(8'h34, 0, "R7 resumes");
        repeat (2 * DIV) @(negedge clk);
    endtask

    task automatic t_flow_off;
        set_cfg(1, 0, 0, 0, 0);
        cts_n = 1'b1;
        push(8'h6B);
        rx(8'h6B, 0, "R8 cts ignored");
        repeat (2 * DIV) @(negedge clk);
    endtask

    task automatic t_fifo_full;
        set_cfg(1, 0, 0, 0, 1);
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        push(8'hC1);
        push(8'hC2);
        push(8'hC3);
        push(8'hC4);
        @(negedge clk);
        check(in_ready == 1'b0, "R11", "ready low when full", 16'(in_ready), 16'h0);
        cts_n = 1'b0;
        rx(8'hC1, 0, "R11 order 1");
        rx(8'hC2, 1, "R11 order 2");
        rx(8'hC3, 1, "R11 order 3");
        rx(8'hC4, 1, "R11 order 4");
        repeat (2 * DIV) @(negedge clk);
        check(in_ready == 1'b1, "R11", "ready after drain", 16'(in_ready), 16'h1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_8n1;
        t_7bit_even;
        t_odd_2stop;
        t_cfg_hold;
        t_flow_block;
        t_cts_mid;
        t_flow_off;
        t_fifo_full;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule